// File: doc/BRIEF.md
# Per-Thread Doorbell Interrupt Controller

This block tracks directed doorbell interrupts for a small group of hardware threads that share one core. Every thread owns two independent pending flags. One is for hypervisor-level doorbells and one is for privileged (supervisor-level) doorbells. Each flag drives its own interrupt request line. Send commands raise a flag on any thread of the core, chosen by a tag in the command operand. Clear commands lower a flag on the issuing thread only. A command has any effect only when the operand carries the one accepted message type. When a thread takes an interrupt, the consumer pulses a per-thread take input, and the matching flag drops.

A shared state register shows the privileged flags of all threads at once, one bit per thread. Hypervisor software can read it and overwrite it. Supervisor software can only read it, and only while the facility-enable input is high. Privileged commands are gated the same way. An access that is refused produces a one-cycle facility-unavailable fault pulse and changes nothing.

Top module: `doorbell_hub`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every interrupt line and the fault pulse are low.
- R2: A command changes state only if operand bits [31:27] equal 5. Any other value leaves every flag unchanged. Reserved types do not suppress the privilege check of R8.
- R3: cmdKind selects the command: 00 is hypervisor send, 01 is hypervisor clear, 10 is privileged send and 11 is privileged clear. A send sets only the flag of its own level (irqHv or irqPriv), and the line rises on the cycle after the command. The other level is never touched.
- R4: A send targets the thread given by operand bits [7:0]. A tag equal to or above the number of threads is ignored.
- R5: A clear lowers the flag of its own level on the thread named by cmdThread, whatever the tag holds. No other thread or level changes.
- R6: regRdata is combinational. It returns the privileged flags in bits [N-1:0] when regRead is high and either regHv or facEnable is high. In every other case it returns all zeros.
- R7: A write with regHv high replaces the privileged flags with regWdata[N-1:0] on the next cycle. Higher write bits are ignored, and the higher read bits stay zero.
- R8: faultPulse goes high for one cycle after any of three accesses: a privileged command (cmdKind[1]=1) with cmdHv and facEnable both low; a read with regHv and facEnable both low; or any write with regHv low. None of these changes any flag.
- R9: A high bit on takeHv or takePriv clears that thread's flag of that level on the next cycle.
- R10: If a send and a clear, take or register write-zero land on the same flag in one cycle, the flag ends up set.
- R11: Privileged commands are accepted with cmdHv high whatever the value of facEnable. They are also accepted with cmdHv low when facEnable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdKind | input | 2 | Command code (R3) |
| cmdHv | input | 1 | Issuer runs in hypervisor state |
| cmdThread | input | 2 | Issuing thread number |
| cmdOperand | input | 64 | Operand: message type [31:27], target tag [7:0] |
| regRead | input | 1 | Read of the shared state register |
| regWrite | input | 1 | Write of the shared state register |
| regHv | input | 1 | Register access made in hypervisor state |
| regWdata | input | 64 | Register write data |
| regRdata | output | 64 | Register read data |
| facEnable | input | 1 | Facility enable for supervisor use |
| takeHv | input | 4 | Per-thread hypervisor doorbell taken |
| takePriv | input | 4 | Per-thread privileged doorbell taken |
| irqHv | output | 4 | Per-thread hypervisor doorbell request |
| irqPriv | output | 4 | Per-thread privileged doorbell request |
| faultPulse | output | 1 | Facility-unavailable fault strobe |

## Verification
Three kinds of event can hit the same privileged flag in one cycle: a send, a clear from a take pulse, and a hypervisor register write of zero. A send and a take can likewise collide on a hypervisor flag. The bench provokes these collisions with directed cycles in which a privileged send meets a write of all zeros, and a hypervisor send meets a take on the targeted thread. A random phase drives commands, takes and register accesses all together, so such overlaps happen often. In every cycle, a bench model built from the rules above predicts the flags, and it expects the send to win (R10).

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  typedef enum logic [1:0] {
    CMD_SEND_HV   = 2'b00,
    CMD_CLR_HV    = 2'b01,
    CMD_SEND_PRIV = 2'b10,
    CMD_CLR_PRIV  = 2'b11
  } dbCmd_t;

  // strobes from the control decode to the flag datapath
  typedef struct packed {
    logic sendHv;
    logic sendPriv;
    logic clrHv;
    logic clrPriv;
    logic wrPriv;
    logic rdOk;
    logic fault;
  } dbStrobe_t;

  function automatic int tidWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int OPER_W      = 64,
  parameter int TAG_W       = 8,
  parameter int TYPE_LSB    = 27,
  parameter int TYPE_W      = 5,
  parameter int MSG_TYPE    = 5
) (
  input  logic                               cmdValid,
  input  logic [1:0]                         cmdKind,
  input  logic                               cmdHv,
  input  logic [tidWidth(NUM_THREADS)-1:0]   cmdThread,
  input  logic [OPER_W-1:0]                  cmdOperand,
  input  logic                               regRead,
  input  logic                               regWrite,
  input  logic                               regHv,
  input  logic                               facEnable,
  output dbStrobe_t                          strobe,
  output logic [tidWidth(NUM_THREADS)-1:0]   sendTarget,
  output logic [tidWidth(NUM_THREADS)-1:0]   clrTarget
);

  localparam int TID_W = tidWidth(NUM_THREADS);

  logic [TYPE_W-1:0] msgType;
  logic [TAG_W-1:0]  tagField;
  logic              typeOk;
  logic              tagOk;
  logic              privCmd;
  logic              cmdAllowed;
  logic              cmdFire;
  logic              cmdFault;
  logic              rdFault;
  logic              wrFault;
  dbCmd_t            kind;

  assign kind     = dbCmd_t'(cmdKind);
  assign msgType  = cmdOperand[TYPE_LSB +: TYPE_W];
  assign tagField = cmdOperand[TAG_W-1:0];
  assign typeOk   = (msgType == TYPE_W'(MSG_TYPE));
  assign tagOk    = ({1'b0, tagField} < (TAG_W+1)'(NUM_THREADS));

  // privileged flavour needs hypervisor state or the facility enable
  assign privCmd    = (kind == CMD_SEND_PRIV) || (kind == CMD_CLR_PRIV);
  assign cmdAllowed = !privCmd || cmdHv || facEnable;
  assign cmdFire    = cmdValid && cmdAllowed && typeOk;

  assign cmdFault = cmdValid && privCmd && !cmdHv && !facEnable;
  assign rdFault  = regRead && !regHv && !facEnable;
  assign wrFault  = regWrite && !regHv;

  assign sendTarget = tagField[TID_W-1:0];
  assign clrTarget  = cmdThread;

  always_comb begin
    strobe          = '0;
    strobe.sendHv   = cmdFire && (kind == CMD_SEND_HV) && tagOk;
    strobe.sendPriv = cmdFire && (kind == CMD_SEND_PRIV) && tagOk;
    strobe.clrHv    = cmdFire && (kind == CMD_CLR_HV);
    strobe.clrPriv  = cmdFire && (kind == CMD_CLR_PRIV);
    strobe.wrPriv   = regWrite && regHv;
    strobe.rdOk     = regRead && (regHv || facEnable);
    strobe.fault    = cmdFault || rdFault || wrFault;
  end

endmodule

// File: rtl/doorbell_state.sv
module doorbell_state
  import doorbell_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int OPER_W      = 64
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dbStrobe_t                          strobe,
  input  logic [tidWidth(NUM_THREADS)-1:0]   sendTarget,
  input  logic [tidWidth(NUM_THREADS)-1:0]   clrTarget,
  input  logic [NUM_THREADS-1:0]             wrBits,
  input  logic [NUM_THREADS-1:0]             takeHv,
  input  logic [NUM_THREADS-1:0]             takePriv,
  output logic [NUM_THREADS-1:0]             hvPend,
  output logic [NUM_THREADS-1:0]             privPend,
  output logic [OPER_W-1:0]                  rdData,
  output logic                               faultQ
);

  localparam int TID_W = tidWidth(NUM_THREADS);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    logic hitSend;
    logic hitClr;
    logic setHv;
    logic clrHv;
    logic setPriv;
    logic clrPriv;

    assign hitSend = (sendTarget == TID_W'(t));
    assign hitClr  = (clrTarget == TID_W'(t));

    assign setHv   = strobe.sendHv && hitSend;
    assign clrHv   = (strobe.clrHv && hitClr) || takeHv[t];
    assign setPriv = (strobe.sendPriv && hitSend) || (strobe.wrPriv && wrBits[t]);
    assign clrPriv = (strobe.clrPriv && hitClr) || takePriv[t]
                   || (strobe.wrPriv && !wrBits[t]);

    // set terms are ORed after the clear mask so a send is never lost
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hvPend[t]   <= 1'b0;
        privPend[t] <= 1'b0;
      end else begin
        hvPend[t]   <= (hvPend[t] && !clrHv) || setHv;
        privPend[t] <= (privPend[t] && !clrPriv) || setPriv;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultQ <= 1'b0;
    else       faultQ <= strobe.fault;
  end

  assign rdData = strobe.rdOk ? OPER_W'(privPend) : '0;

endmodule

// File: rtl/doorbell_hub.sv
module doorbell_hub
  import doorbell_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int OPER_W      = 64,
  parameter int TAG_W       = 8,
  parameter int TYPE_LSB    = 27,
  parameter int TYPE_W      = 5,
  parameter int MSG_TYPE    = 5
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               cmdValid,
  input  logic [1:0]                         cmdKind,
  input  logic                               cmdHv,
  input  logic [tidWidth(NUM_THREADS)-1:0]   cmdThread,
  input  logic [OPER_W-1:0]                  cmdOperand,
  input  logic                               regRead,
  input  logic                               regWrite,
  input  logic                               regHv,
  input  logic [OPER_W-1:0]                  regWdata,
  output logic [OPER_W-1:0]                  regRdata,
  input  logic                               facEnable,
  input  logic [NUM_THREADS-1:0]             takeHv,
  input  logic [NUM_THREADS-1:0]             takePriv,
  output logic [NUM_THREADS-1:0]             irqHv,
  output logic [NUM_THREADS-1:0]             irqPriv,
  output logic                               faultPulse
);

  localparam int TID_W = tidWidth(NUM_THREADS);

  dbStrobe_t        strobe;
  logic [TID_W-1:0] sendTarget;
  logic [TID_W-1:0] clrTarget;

  doorbell_ctrl #(
    .NUM_THREADS(NUM_THREADS), .OPER_W(OPER_W), .TAG_W(TAG_W),
    .TYPE_LSB(TYPE_LSB), .TYPE_W(TYPE_W), .MSG_TYPE(MSG_TYPE)
  ) u_ctrl (
    .cmdValid  (cmdValid),
    .cmdKind   (cmdKind),
    .cmdHv     (cmdHv),
    .cmdThread (cmdThread),
    .cmdOperand(cmdOperand),
    .regRead   (regRead),
    .regWrite  (regWrite),
    .regHv     (regHv),
    .facEnable (facEnable),
    .strobe    (strobe),
    .sendTarget(sendTarget),
    .clrTarget (clrTarget)
  );

  doorbell_state #(
    .NUM_THREADS(NUM_THREADS), .OPER_W(OPER_W)
  ) u_state (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sendTarget(sendTarget),
    .clrTarget (clrTarget),
    .wrBits    (regWdata[NUM_THREADS-1:0]),
    .takeHv    (takeHv),
    .takePriv  (takePriv),
    .hvPend    (irqHv),
    .privPend  (irqPriv),
    .rdData    (regRdata),
    .faultQ    (faultPulse)
  );

endmodule

// File: rtl/doorbell_hub_chk.sv
module doorbell_hub_chk
  import doorbell_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int OPER_W      = 64,
  parameter int TAG_W       = 8,
  parameter int TYPE_LSB    = 27,
  parameter int TYPE_W      = 5,
  parameter int MSG_TYPE    = 5
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               cmdValid,
  input logic [1:0]                         cmdKind,
  input logic                               cmdHv,
  input logic [tidWidth(NUM_THREADS)-1:0]   cmdThread,
  input logic [OPER_W-1:0]                  cmdOperand,
  input logic                               regRead,
  input logic                               regWrite,
  input logic                               regHv,
  input logic [OPER_W-1:0]                  regWdata,
  input logic [OPER_W-1:0]                  regRdata,
  input logic                               facEnable,
  input logic [NUM_THREADS-1:0]             takeHv,
  input logic [NUM_THREADS-1:0]             takePriv,
  input logic [NUM_THREADS-1:0]             irqHv,
  input logic [NUM_THREADS-1:0]             irqPriv,
  input logic                               faultPulse
);

  localparam int TID_W = tidWidth(NUM_THREADS);

  logic typeOk;
  logic tagOk;
  logic [TID_W-1:0] tagIdx;
  logic quietOthers;
  logic anyFaultCause;

  assign typeOk = (cmdOperand[TYPE_LSB +: TYPE_W] == TYPE_W'(MSG_TYPE));
  assign tagOk  = ({1'b0, cmdOperand[TAG_W-1:0]} < (TAG_W+1)'(NUM_THREADS));
  assign tagIdx = cmdOperand[TID_W-1:0];
  assign quietOthers = !regWrite && (takeHv == '0) && (takePriv == '0);
  assign anyFaultCause = (cmdValid && cmdKind[1] && !cmdHv && !facEnable)
                       || (regRead && !regHv && !facEnable)
                       || (regWrite && !regHv);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (irqHv == '0 && irqPriv == '0 && !faultPulse));

  a_r2_reserved_type: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !typeOk && quietOthers) |=> ($stable(irqHv) && $stable(irqPriv)));

  a_r3_no_alias: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 2'b00 && quietOthers) |=> $stable(irqPriv));

  a_r6_read_gated: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && !regHv && !facEnable) |-> (regRdata == '0));

  a_r7_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((regRdata >> NUM_THREADS) == '0));

  a_r8_fault_raised: assert property (@(posedge clk) disable iff (!rstN)
    anyFaultCause |=> faultPulse);

  a_r8_fault_cause: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> $past(anyFaultCause));

  a_r9_take_clears: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !regWrite && takePriv != '0) |=> ((irqPriv & $past(takePriv)) == '0));

  a_r10_send_wins: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 2'b10 && typeOk && tagOk && (cmdHv || facEnable))
      |=> irqPriv[$past(tagIdx)]);

endmodule

bind doorbell_hub doorbell_hub_chk #(
  .NUM_THREADS(NUM_THREADS), .OPER_W(OPER_W), .TAG_W(TAG_W),
  .TYPE_LSB(TYPE_LSB), .TYPE_W(TYPE_W), .MSG_TYPE(MSG_TYPE)
) u_chk (.*);

// File: tb/doorbell_hub_tb.sv
module doorbell_hub_tb;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid;
  logic [1:0]  cmdKind;
  logic        cmdHv;
  logic [1:0]  cmdThread;
  logic [63:0] cmdOperand;
  logic        regRead;
  logic        regWrite;
  logic        regHv;
  logic [63:0] regWdata;
  logic [63:0] regRdata;
  logic        facEnable;
  logic [N-1:0] takeHv;
  logic [N-1:0] takePriv;
  logic [N-1:0] irqHv;
  logic [N-1:0] irqPriv;
  logic        faultPulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [N-1:0] mHv = '0;
  logic [N-1:0] mPriv = '0;

  always #2 clk = ~clk;

  doorbell_hub u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdHv(cmdHv), .cmdThread(cmdThread), .cmdOperand(cmdOperand),
    .regRead(regRead), .regWrite(regWrite), .regHv(regHv),
    .regWdata(regWdata), .regRdata(regRdata), .facEnable(facEnable),
    .takeHv(takeHv), .takePriv(takePriv), .irqHv(irqHv),
    .irqPriv(irqPriv), .faultPulse(faultPulse)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] mkOp(input logic [4:0] typ, input logic [7:0] tag,
                                       input logic [18:0] noise);
    return {32'hA5A5_0000, typ, noise, tag};
  endfunction

  task automatic idle();
    cmdValid = 0; cmdKind = 0; cmdHv = 0; cmdThread = 0; cmdOperand = '0;
    regRead = 0; regWrite = 0; regHv = 0; regWdata = '0; facEnable = 0;
    takeHv = '0; takePriv = '0;
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // inputs are already driven; predict, clock, compare
  task automatic step(input string req);
    logic [N-1:0] sH, cH, sP, cP;
    logic eFault, allow, typeOk;
    logic [7:0] tag;
    logic [63:0] eRd;
    sH = '0; cH = '0; sP = '0; cP = '0;
    #1;
    eRd = (regRead && (regHv || facEnable)) ? 64'(mPriv) : 64'd0;
    check(req, "regRdata", regRdata, eRd);
    typeOk = (cmdOperand[31:27] == 5'd5);
    tag    = cmdOperand[7:0];
    allow  = !cmdKind[1] || cmdHv || facEnable;
    eFault = (cmdValid && cmdKind[1] && !cmdHv && !facEnable)
          || (regRead && !regHv && !facEnable) || (regWrite && !regHv);
    if (cmdValid && allow && typeOk) begin
      if (!cmdKind[0]) begin
        if (tag < N) begin
          if (cmdKind[1]) sP[tag[1:0]] = 1'b1;
          else            sH[tag[1:0]] = 1'b1;
        end
      end else begin
        if (cmdKind[1]) cP[cmdThread] = 1'b1;
        else            cH[cmdThread] = 1'b1;
      end
    end
    cH |= takeHv;
    cP |= takePriv;
    if (regWrite && regHv) begin
      sP |= regWdata[N-1:0];
      cP |= ~regWdata[N-1:0];
    end
    mHv   = (mHv & ~cH) | sH;
    mPriv = (mPriv & ~cP) | sP;
    @(posedge clk);
    @(negedge clk);
    check(req, "irqHv", 64'(irqHv), 64'(mHv));
    check(req, "irqPriv", 64'(irqPriv), 64'(mPriv));
    check(req, "faultPulse", 64'(faultPulse), 64'(eFault));
    idle();
  endtask

  task automatic sendCmd(input logic [1:0] kind, input logic hv, input logic fe,
                         input logic [1:0] thr, input logic [63:0] op);
    cmdValid = 1; cmdKind = kind; cmdHv = hv; facEnable = fe;
    cmdThread = thr; cmdOperand = op;
  endtask

  initial begin
    idle();
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "irqHv", 64'(irqHv), 64'd0);
    check("R1", "irqPriv", 64'(irqPriv), 64'd0);
    check("R1", "faultPulse", 64'(faultPulse), 64'd0);
    rstN = 1'b1;
    step("R1");

    // R3: hypervisor send to thread 2, privileged flags untouched
    sendCmd(2'b00, 1, 0, 0, mkOp(5, 2, 19'h1234)); step("R3");
    // R3 R11: privileged send from hypervisor state with enable low
    sendCmd(2'b10, 1, 0, 3, mkOp(5, 1, 19'h0)); step("R11");
    // R2: reserved types 4 and 31
    sendCmd(2'b00, 1, 0, 0, mkOp(4, 0, 19'h0)); step("R2");
    sendCmd(2'b10, 1, 1, 0, mkOp(31, 3, 19'h7)); step("R2");
    // R4: tags at and beyond thread count
    sendCmd(2'b00, 1, 0, 0, mkOp(5, 4, 19'h0)); step("R4");
    sendCmd(2'b10, 1, 0, 0, mkOp(5, 8'hFF, 19'h0)); step("R4");
    sendCmd(2'b00, 1, 0, 0, mkOp(5, 3, 19'h0)); step("R4");
    // R5: clear from thread 2 with tag 3 clears thread 2 only
    sendCmd(2'b01, 1, 0, 2, mkOp(5, 3, 19'h0)); step("R5");
    // R6: hypervisor read
    regRead = 1; regHv = 1; step("R6");
    // R8: supervisor read without enable
    regRead = 1; regHv = 0; facEnable = 0; step("R8");
    // R6: supervisor read with enable
    regRead = 1; regHv = 0; facEnable = 1; step("R6");
    // R7: hypervisor write with junk in high bits, then read
    regWrite = 1; regHv = 1; regWdata = 64'hFFFF_FFF0_0000_0005; step("R7");
    regRead = 1; regHv = 1; step("R7");
    // R8: supervisor write even with enable
    regWrite = 1; regHv = 0; facEnable = 1; regWdata = 64'hF; step("R8");
    // R8: privileged send and clear from supervisor without enable
    sendCmd(2'b10, 0, 0, 0, mkOp(5, 1, 19'h0)); step("R8");
    sendCmd(2'b11, 0, 0, 0, mkOp(5, 0, 19'h0)); step("R8");
    // R8: reserved type still faults
    sendCmd(2'b10, 0, 0, 0, mkOp(2, 1, 19'h0)); step("R8");
    // R11: privileged send from supervisor with enable
    sendCmd(2'b10, 0, 1, 0, mkOp(5, 1, 19'h0)); step("R11");
    // R9: takes
    takePriv = 4'b0011; step("R9");
    takeHv = 4'b1111; step("R9");
    // R10: send meets take on same thread
    sendCmd(2'b00, 1, 0, 0, mkOp(5, 2, 19'h0)); takeHv = 4'b0100; step("R10");
    // R10: privileged send meets hypervisor write of zero
    sendCmd(2'b10, 1, 0, 0, mkOp(5, 3, 19'h0));
    regWrite = 1; regHv = 1; regWdata = '0; step("R10");
    // R10: privileged send meets privileged take on same thread
    sendCmd(2'b10, 1, 0, 0, mkOp(5, 3, 19'h0)); takePriv = 4'b1000; step("R10");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      cmdValid   = ($urandom_range(0, 3) != 0);
      cmdKind    = 2'($urandom_range(0, 3));
      cmdHv      = 1'($urandom_range(0, 1));
      facEnable  = 1'($urandom_range(0, 1));
      cmdThread  = 2'($urandom_range(0, 3));
      cmdOperand = mkOp(($urandom_range(0, 3) != 0) ? 5'd5 : 5'($urandom_range(0, 31)),
                        8'($urandom_range(0, 5)), 19'($urandom));
      regRead    = ($urandom_range(0, 3) == 0);
      regWrite   = ($urandom_range(0, 7) == 0);
      regHv      = 1'($urandom_range(0, 1));
      regWdata   = {$urandom, $urandom};
      takeHv     = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'd0;
      takePriv   = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'd0;
      step("R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule